// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is a synthesizable model of a small serial EEPROM that sits on an SPI bus as a target. A host frames each command with chip select held low and sends a one-byte opcode, then, for data commands, an address of one to three bytes with the most significant byte first. Data reads stream bytes from an internal byte array for as long as chip select stays low. Data writes collect bytes into a page buffer and store them in the array only when the frame ends cleanly. A status byte reports the write enable latch, a busy flag, two block-protect bits and a write-protect enable bit.

The SPI pins are oversampled by the system clock `clk`, so SCLK must be several times slower than `clk`. The bus works in mode 0. A data or status write is accepted only when the write enable latch has been set by an earlier command. A stored write then holds the part busy for a fixed number of `clk` cycles. In the nine-bit address configuration, a single address byte is sent and opcode bit 3 supplies address bit 8.

Top module: `spi_ee_target`

## Requirements
- R1: The bus is SPI mode 0. MOSI is sampled on the rising SCLK edge, MSB first. MISO changes only while SCLK is low. While `cs_n` is low, MISO is stable throughout every high phase of SCLK.
- R2: Opcode 0x05 returns the status byte, repeated for as long as `cs_n` stays low and re-evaluated for each byte. The status bits are: bit 0 busy, bit 1 write enable latch, bits 3:2 block-protect, bit 7 write-protect enable, and bits 6:4 zero.
- R3: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it.
- R4: Opcode 0x03, followed by the address, streams the byte at that address and then the following bytes in order. The address wraps from the last array byte to byte 0.
- R5: When `NINE_BIT` is set, bit 3 of the read and write opcodes is address bit 8. Read is 0x03 or 0x0B and write is 0x02 or 0x0A, each followed by one address byte.
- R6: Opcode 0x02 with the latch set stores the data bytes from the address upward. The offset wraps inside the `PAGE_BYTES` page, so later bytes overwrite the start of that page.
- R7: A data write or status write issued while the latch is clear leaves the array and the status unchanged, and does not start a busy interval.
- R8: When `cs_n` rises after an accepted data write or status write, the write enable latch is cleared, whether or not the write was stored.
- R9: A data write is stored only if `cs_n` rises on a byte boundary. If it rises after a partial byte, no byte of that frame is stored and no busy interval starts.
- R10: A stored data or status write sets the busy bit for exactly `BUSY_CYCLES` clock cycles.
- R11: While busy, every opcode other than 0x05 is ignored. For example, 0x06 does not set the latch, and a read returns 0x00 bytes.
- R12: Opcode 0x01 with the latch set loads status bits 7, 3 and 2 from the first data byte when the frame ends. The other status bits are not affected by the data.
- R13: After reset, the status reads 0x00 and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | SPI serial clock from the host, idles low |
| cs_n | input | 1 | Chip select, active low, frames each command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A write enable latch left in the wrong state appears at bit 1 of the next status read. It also shows up one frame later: a write that should have landed is missing from a read-back, or a write that should have been refused has landed. A wrong busy count appears at bit 0 during the polling that follows a write, within a few status bytes. A stale page mask or a wrong page offset appears as a wrong byte, or a byte lost from another part of the page, when the whole page is read back. A MISO load taken from the wrong edge or the wrong source shifts every returned bit within the first byte of the data phase.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    // Command opcodes seen on MOSI
    localparam logic [7:0] OP_WEN_SET  = 8'h06;
    localparam logic [7:0] OP_WEN_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_DATA_RD  = 8'h03;
    localparam logic [7:0] OP_DATA_WR  = 8'h02;
    // Opcode bit that carries address bit 8 in nine-bit mode
    localparam int         OP_HI_ADDR_BIT = 3;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_STAT_RD,
        PH_STAT_WR,
        PH_IGNORE
    } phase_e;
endpackage

// File: rtl/spi_ee_shifter.sv
// Oversampled SPI mode-0 byte shifter: samples MOSI on rising SCLK,
// reloads or shifts MISO on falling SCLK.
module spi_ee_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       frame_end,
    output logic       on_boundary
);
    typedef struct packed {
        logic       sclk;
        logic       cs_n;
        logic [2:0] bit_cnt;
        logic [6:0] rx_sh;
        logic [7:0] tx_sh;
        logic       vld;
        logic [7:0] rx_byte;
    } shf_t;

    localparam shf_t SHF_RST = '{sclk: 1'b0, cs_n: 1'b1, bit_cnt: '0, rx_sh: '0,
                                 tx_sh: '0, vld: 1'b0, rx_byte: '0};

    shf_t s_d, s_q;
    logic rise, fall;

    assign rise = sclk & ~s_q.sclk;
    assign fall = ~sclk & s_q.sclk;

    always_comb begin
        s_d      = s_q;
        s_d.sclk = sclk;
        s_d.cs_n = cs_n;
        s_d.vld  = 1'b0;
        if (cs_n) begin
            s_d.bit_cnt = '0;
            s_d.tx_sh   = '0;
        end else begin
            if (rise) begin
                s_d.rx_sh   = {s_q.rx_sh[5:0], mosi};
                s_d.bit_cnt = s_q.bit_cnt + 3'd1;
                if (s_q.bit_cnt == 3'd7) begin
                    s_d.vld     = 1'b1;
                    s_d.rx_byte = {s_q.rx_sh, mosi};
                end
            end
            if (fall) begin
                if (s_q.bit_cnt == 3'd0) s_d.tx_sh = tx_byte;
                else                     s_d.tx_sh = {s_q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SHF_RST;
        else        s_q <= s_d;
    end

    assign miso        = s_q.tx_sh[7];
    assign byte_valid  = s_q.vld;
    assign rx_byte     = s_q.rx_byte;
    assign frame_end   = cs_n & ~s_q.cs_n;
    assign on_boundary = (s_q.bit_cnt == 3'd0);
endmodule

// File: rtl/spi_ee_array.sv
// Byte array with one read port and a masked whole-page write port.
module spi_ee_array #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int PIDX_W    = ADDR_W - PAGE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [7:0]                   rd_data,
    input  logic                         wr_en,
    input  logic [PIDX_W-1:0]            wr_page,
    input  logic [PAGE_BYTES-1:0][7:0]   wr_data,
    input  logic [PAGE_BYTES-1:0]        wr_mask
);
    logic [7:0] cells [MEM_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) cells[i] <= '0;
        end else if (wr_en) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (wr_mask[j]) cells[{wr_page, PAGE_W'(j)}] <= wr_data[j];
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_ee_target.sv
module spi_ee_target
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BYTES  = 1,
    parameter int NINE_BIT    = 1,
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int ADDR_W  = $clog2(MEM_BYTES);
    localparam int PAGE_W  = $clog2(PAGE_BYTES);
    localparam int PIDX_W  = ADDR_W - PAGE_W;
    localparam int ACC_W   = 8 * ADDR_BYTES;
    localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);
    localparam logic [7:0] OP_MASK = (NINE_BIT != 0) ? ~(8'h01 << OP_HI_ADDR_BIT) : 8'hFF;

    typedef struct packed {
        phase_e                      phase;
        logic                        is_wr;
        logic                        hi_bit;
        logic [ACC_W-1:0]            acc;
        logic [1:0]                  abyte;
        logic [ADDR_W-1:0]           addr;
        logic                        wel;
        logic [1:0]                  bp;
        logic                        wpen;
        logic                        busy;
        logic [BUSY_W-1:0]           bcnt;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pmask;
        logic [7:0]                  sr_new;
        logic                        sr_pend;
        logic                        wr_armed;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             byte_valid, frame_end, on_boundary;
    logic [7:0]       rx_byte, tx_byte, mem_rdata, status, op_core;
    logic [ACC_W-1:0] acc_next;
    logic [ADDR_W-1:0] addr_new;
    logic [PAGE_W-1:0] off;
    logic             commit_pg;
    logic             busy_w, wel_w;

    spi_ee_shifter u_shifter (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_byte), .miso(miso), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .frame_end(frame_end), .on_boundary(on_boundary)
    );

    spi_ee_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(c_q.addr), .rd_data(mem_rdata),
        .wr_en(commit_pg), .wr_page(c_q.addr[ADDR_W-1:PAGE_W]),
        .wr_data(c_q.pbuf), .wr_mask(c_q.pmask)
    );

    // Address byte accumulation, MSB first
    if (ADDR_BYTES == 1) begin : g_acc1
        assign acc_next = rx_byte;
    end else begin : g_accn
        assign acc_next = {c_q.acc[ACC_W-9:0], rx_byte};
    end

    // Final address: opcode bit supplies bit 8 in nine-bit mode
    if (NINE_BIT != 0) begin : g_nine
        assign addr_new = ADDR_W'({c_q.hi_bit, acc_next[7:0]});
    end else begin : g_plain
        assign addr_new = ADDR_W'(acc_next);
    end

    assign op_core = rx_byte & OP_MASK;
    assign off     = c_q.addr[PAGE_W-1:0];
    assign status  = {c_q.wpen, 3'b000, c_q.bp, c_q.wel, c_q.busy};

    always_comb begin
        case (c_q.phase)
            PH_STAT_RD: tx_byte = status;
            PH_RD_DATA: tx_byte = mem_rdata;
            default:    tx_byte = 8'h00;
        endcase
    end

    always_comb begin
        c_d       = c_q;
        commit_pg = 1'b0;

        if (c_q.busy) begin
            if (c_q.bcnt <= BUSY_W'(1)) begin
                c_d.busy = 1'b0;
                c_d.bcnt = '0;
            end else begin
                c_d.bcnt = c_q.bcnt - BUSY_W'(1);
            end
        end

        if (frame_end) begin
            if (c_q.wr_armed) c_d.wel = 1'b0;
            if (on_boundary && c_q.phase == PH_WR_DATA && (|c_q.pmask)) begin
                commit_pg = 1'b1;
                c_d.busy  = 1'b1;
                c_d.bcnt  = BUSY_W'(BUSY_CYCLES);
            end
            if (on_boundary && c_q.phase == PH_STAT_WR && c_q.sr_pend) begin
                c_d.bp   = c_q.sr_new[3:2];
                c_d.wpen = c_q.sr_new[7];
                c_d.busy = 1'b1;
                c_d.bcnt = BUSY_W'(BUSY_CYCLES);
            end
            c_d.phase    = PH_OPCODE;
            c_d.wr_armed = 1'b0;
            c_d.sr_pend  = 1'b0;
            c_d.pmask    = '0;
            c_d.abyte    = '0;
        end else if (byte_valid) begin
            case (c_q.phase)
                PH_OPCODE: begin
                    c_d.hi_bit = rx_byte[OP_HI_ADDR_BIT];
                    c_d.abyte  = '0;
                    c_d.acc    = '0;
                    c_d.phase  = PH_IGNORE;
                    if (rx_byte == OP_STAT_RD) begin
                        c_d.phase = PH_STAT_RD;
                    end else if (!c_q.busy) begin
                        if (rx_byte == OP_WEN_SET) begin
                            c_d.wel = 1'b1;
                        end else if (rx_byte == OP_WEN_CLR) begin
                            c_d.wel = 1'b0;
                        end else if (rx_byte == OP_STAT_WR) begin
                            if (c_q.wel) begin
                                c_d.phase    = PH_STAT_WR;
                                c_d.wr_armed = 1'b1;
                            end
                        end else if (op_core == OP_DATA_RD) begin
                            c_d.phase = PH_ADDR;
                            c_d.is_wr = 1'b0;
                        end else if (op_core == OP_DATA_WR) begin
                            if (c_q.wel) begin
                                c_d.phase    = PH_ADDR;
                                c_d.is_wr    = 1'b1;
                                c_d.wr_armed = 1'b1;
                                c_d.pmask    = '0;
                            end
                        end
                    end
                end
                PH_ADDR: begin
                    c_d.acc   = acc_next;
                    c_d.abyte = c_q.abyte + 2'd1;
                    if (c_q.abyte == 2'(ADDR_BYTES - 1)) begin
                        c_d.addr  = addr_new;
                        c_d.phase = c_q.is_wr ? PH_WR_DATA : PH_RD_DATA;
                    end
                end
                PH_RD_DATA: c_d.addr = c_q.addr + ADDR_W'(1);
                PH_WR_DATA: begin
                    c_d.pbuf[off]  = rx_byte;
                    c_d.pmask[off] = 1'b1;
                    c_d.addr       = {c_q.addr[ADDR_W-1:PAGE_W], PAGE_W'(off + PAGE_W'(1))};
                end
                PH_STAT_WR: begin
                    if (!c_q.sr_pend) begin
                        c_d.sr_new  = rx_byte;
                        c_d.sr_pend = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_w = c_q.busy;
    assign wel_w  = c_q.wel;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
    parameter int BUSY_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic miso,
    input logic busy,
    input logic wel,
    input logic commit
);
    localparam int CW = $clog2(BUSY_CYCLES + 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + CW'(1);
        else           run_q <= '0;
    end

    AST_MISO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk) && $past(!cs_n)) |-> $stable(miso)); // R1
    AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R10
    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy); // R11
    AST_COMMIT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel); // R8
    AST_WEL_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(!busy)); // R11
    AST_BUSY_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < CW'(BUSY_CYCLES))); // R10
    AST_BUSY_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == CW'(BUSY_CYCLES))); // R10
endmodule

bind spi_ee_target spi_ee_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .miso(miso),
    .busy(busy_w), .wel(wel_w), .commit(commit_pg)
);

// File: tb/spi_ee_target_bench.sv
module spi_ee_target_bench;
    localparam int MEM   = 512;
    localparam int PAGE  = 16;
    localparam int BUSY  = 400;
    localparam int HALF  = 4;

    // {9-bit address, data} pairs written then read back
    localparam logic [16:0] VEC [6] = '{
        {9'h000, 8'h11}, {9'h001, 8'h22}, {9'h0FF, 8'hC3},
        {9'h100, 8'h5A}, {9'h1FE, 8'h7E}, {9'h1FF, 8'hA5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MEM];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];

    always #2 clk = ~clk;

    spi_ee_target #(.ADDR_BYTES(1), .NINE_BIT(1), .MEM_BYTES(MEM),
                    .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u_spi_ee_target (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_close();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op);
        logic [7:0] d;
        frame_open();
        xfer(op, d);
        frame_close();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, s);
        frame_close();
    endtask

    task automatic wait_idle(output int polls);
        logic [7:0] s;
        polls = 0;
        for (int k = 0; k < 50; k++) begin
            rd_status(s);
            polls++;
            if (!s[0]) break;
        end
    endtask

    task automatic write_seq(input logic [8:0] addr, input int n, input bit upd);
        logic [7:0] d;
        frame_open();
        xfer(8'h02 | {4'b0, addr[8], 3'b0}, d);
        xfer(addr[7:0], d);
        for (int k = 0; k < n; k++) begin
            xfer(wbuf[k], d);
            if (upd) model[{addr[8:4], 4'(addr[3:0] + 4'(k))}] = wbuf[k];
        end
        frame_close();
    endtask

    task automatic read_seq(input logic [8:0] addr, input int n);
        logic [7:0] d;
        frame_open();
        xfer(8'h03 | {4'b0, addr[8], 3'b0}, d);
        xfer(addr[7:0], d);
        for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
        frame_close();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] s;
        logic [7:0] d;
        int polls;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R13 reset state
        rd_status(s);
        check("R13 status after reset", {8'h0, s}, 16'h0000);
        read_seq(9'h000, 1);
        check("R13 array after reset", {8'h0, rbuf[0]}, 16'h0000);

        // Vector table: write then read back, nine-bit addresses (R5, R6, R1)
        for (int v = 0; v < 6; v++) begin
            one_byte_cmd(8'h06);
            wbuf[0] = VEC[v][7:0];
            write_seq(VEC[v][16:8], 1, 1'b1);
            wait_idle(polls);
            read_seq(VEC[v][16:8], 1);
            check("R5 R6 table readback", {8'h0, rbuf[0]}, {8'h0, VEC[v][7:0]});
        end
        read_seq(9'h000, 1);
        check("R5 bit8 keeps low half distinct", {8'h0, rbuf[0]}, 16'h0011);

        // R3 latch set and clear
        one_byte_cmd(8'h06);
        rd_status(s);
        check("R3 latch set", {8'h0, s}, 16'h0002);
        one_byte_cmd(8'h04);
        rd_status(s);
        check("R3 latch clear", {8'h0, s}, 16'h0000);

        // R7 write without latch
        wbuf[0] = 8'hEE;
        write_seq(9'h010, 1, 1'b0);
        rd_status(s);
        check("R7 no busy after refused write", {8'h0, s}, 16'h0000);
        read_seq(9'h010, 1);
        check("R7 array unchanged", {8'h0, rbuf[0]}, {8'h0, model[9'h010]});

        // R4 sequential read wrapping at array end
        read_seq(9'h1FE, 4);
        for (int k = 0; k < 4; k++)
            check("R4 stream wrap", {8'h0, rbuf[k]}, {8'h0, model[9'((9'h1FE + k) % MEM)]});

        // R6 page wrap
        one_byte_cmd(8'h06);
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
        write_seq(9'h02E, 4, 1'b1);
        wait_idle(polls);
        read_seq(9'h020, 17);
        for (int k = 0; k < 17; k++)
            check("R6 page wrap content", {8'h0, rbuf[k]}, {8'h0, model[9'h020 + 9'(k)]});

        // R10 R2 R8: busy right after write, streaming status until idle
        one_byte_cmd(8'h06);
        wbuf[0] = 8'h3C;
        write_seq(9'h080, 1, 1'b1);
        frame_open();
        xfer(8'h05, d);
        xfer(8'h00, s);
        check("R10 R8 busy set latch cleared", {8'h0, s}, 16'h0001);
        polls = 0;
        while (s[0] && polls < 40) begin
            xfer(8'h00, s);
            polls++;
        end
        frame_close();
        check("R2 R10 streamed status reaches idle", {8'h0, s}, 16'h0000);

        // R11 opcodes ignored while busy
        one_byte_cmd(8'h06);
        wbuf[0] = 8'h96;
        write_seq(9'h081, 1, 1'b1);
        one_byte_cmd(8'h06);
        read_seq(9'h1FF, 1);
        check("R11 read ignored while busy", {8'h0, rbuf[0]}, 16'h0000);
        wait_idle(polls);
        rd_status(s);
        check("R11 latch set ignored while busy", {8'h0, s}, 16'h0000);
        read_seq(9'h080, 2);
        check("R11 earlier write intact", {8'h0, rbuf[0]}, 16'h003C);
        check("R11 later write stored", {8'h0, rbuf[1]}, 16'h0096);

        // R9 partial byte aborts the write
        one_byte_cmd(8'h06);
        frame_open();
        xfer(8'h02, d);
        xfer(8'h50, d);
        xfer(8'h77, d);
        xfer_bits(8'hE0, 3, d);
        frame_close();
        rd_status(s);
        check("R9 R8 no busy and latch cleared", {8'h0, s}, 16'h0000);
        read_seq(9'h050, 1);
        check("R9 nothing stored", {8'h0, rbuf[0]}, {8'h0, model[9'h050]});

        // R12 status write, R7 refused status write
        one_byte_cmd(8'h06);
        frame_open();
        xfer(8'h01, d);
        xfer(8'hFF, d);
        frame_close();
        wait_idle(polls);
        rd_status(s);
        check("R12 status bits loaded", {8'h0, s}, 16'h008C);
        frame_open();
        xfer(8'h01, d);
        xfer(8'h00, d);
        frame_close();
        rd_status(s);
        check("R7 status write refused", {8'h0, s}, 16'h008C);
        one_byte_cmd(8'h06);
        frame_open();
        xfer(8'h01, d);
        xfer(8'h00, d);
        frame_close();
        wait_idle(polls);
        rd_status(s);
        check("R12 status bits cleared", {8'h0, s}, 16'h0000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule